// File: doc/BRIEF.md
# Windowed Pulse Timing Checker

This block checks the timing of a returned pulse train, one segment at a time. A frame-start strobe arms it. After that it waits for the first falling edge of the waveform under test. From that edge on, it times each low pulse and each high gap as a count of 1 us tick strobes. When the edge that ends a segment arrives, it compares the count with that segment's own expected duration, widened by a symmetric tolerance. The expected frame has `NUM_PULSES` low pulses of `PULSE_US`, with high gaps of `GAP_US` between them. It ends with a high trailing interval of `TRAIL_US`, and the edge that closes that interval completes the frame.

Every failing segment produces a one-clock error pulse, clears the run of good frames and forces the no-go indicator. Go is raised only once `PASS_RUN` frames in a row have passed. It stays up for as long as frames keep passing. A frame that is still unfinished when the next frame-start strobe arrives counts as a failure. All expected durations and the tolerance are elaboration-time parameters.

Top module: `pulseTimingChecker`

## Requirements
- R1: Segment length is measured as the number of `tick` strobes from the edge that starts the segment up to, but not including, the edge that ends it. A tick in the cycle of an edge counts toward the new segment.
- R2: After frame start, the first falling edge opens segment 0. Segments alternate low and high. Segment i is expected to last `PULSE_US` for even i, `GAP_US` for odd i, and `TRAIL_US` for the last segment (index 2*NUM_PULSES-1). The edge that ends that last segment completes the frame.
- R3: A segment passes when expected-TOL_US <= measured <= expected+TOL_US, so both limits are inclusive.
- R4: Each failing segment drives `segErr` high for exactly one clock. The frame goes on being checked, so two failing segments give two pulses.
- R5: Any failure clears the consecutive-pass count, drives `noGo` high and `go` low. `go` and `noGo` are never high together.
- R6: A complete frame with no failing segment adds one to the consecutive-pass count. When the count reaches `PASS_RUN` (default 13), `go` rises and `noGo` falls. Before that, `go` stays low.
- R7: While `go` is high, further passing frames keep it high.
- R8: A frame-start strobe that arrives while a frame is armed or being measured counts as a failure (one `segErr` pulse, R5 effects) and arms a new frame.
- R9: After reset `go`, `noGo` and `segErr` are low. The first frame-start strobe after reset, or one arriving after a completed frame, is not a failure.
- R10: Edges seen while no frame is armed, and rising edges while waiting for the first falling edge, have no effect on any output.
- R11: The duration counter saturates instead of wrapping, so a segment far longer than its window fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe every 1 us |
| frameStart | input | 1 | One-clock strobe that arms a new frame |
| waveIn | input | 1 | Waveform under test (asynchronous, synchronised inside) |
| go | output | 1 | High after PASS_RUN consecutive passing frames |
| noGo | output | 1 | High after any failure until go is reached |
| segErr | output | 1 | One-clock pulse per failing segment or aborted frame |

## Verification
The in-line properties check, on every cycle, the invariants of the verdict and of the counter. Go and no-go are never high together. Go rises only with a full run and holds unless a failure arrives. An error pulse always carries no-go. An aborted frame produces a pulse. The counter steps by one per tick and holds at saturation. Only the bench's scenarios can show the behaviours that need whole frames. These are inclusive window limits at exactly the tolerance, segment-specific expected values (a trailing interval timed like a gap fails), the count of 13 before go, the rejection of a wrap-length pulse, and the fact that stray edges outside an armed frame change nothing.

// File: rtl/pulseChkPkg.sv
package pulseChkPkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ARM,
    S_MEAS
  } chkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic checkEn;
  } ctlStrobe_t;

  // strobes from datapath to control
  typedef struct packed {
    logic fall;
    logic segPass;
    logic segMiss;
  } dpStatus_t;

  // expected duration of segment idx within a frame of nSeg segments
  function automatic int segExpect(int idx, int nSeg, int pulseUs, int gapUs, int trailUs);
    if (idx == nSeg - 1) return trailUs;
    else if (idx % 2 == 0) return pulseUs;
    else return gapUs;
  endfunction

endpackage

// File: rtl/pulseChkDatapath.sv
module pulseChkDatapath
  import pulseChkPkg::*;
#(
  parameter int NUM_SEG  = 12,
  parameter int PULSE_US = 1500,
  parameter int GAP_US   = 200,
  parameter int TRAIL_US = 200,
  parameter int TOL_US   = 10,
  parameter int CNT_W    = 11,
  parameter int SEG_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             waveIn,
  input  ctlStrobe_t       ctl,
  input  logic [SEG_W-1:0] segIdx,
  output dpStatus_t        st
);

  logic [1:0]       waveSync;
  logic             wavePrev;
  logic             edgeNow;
  logic             fallNow;
  logic [CNT_W-1:0] segCnt;
  logic [CNT_W-1:0] loLim [NUM_SEG];
  logic [CNT_W-1:0] hiLim [NUM_SEG];
  logic             inWindow;

  // per-segment window limits
  for (genvar g = 0; g < NUM_SEG; g++) begin : gLim
    localparam int EXP = segExpect(g, NUM_SEG, PULSE_US, GAP_US, TRAIL_US);
    localparam int LO  = (EXP > TOL_US) ? EXP - TOL_US : 0;
    localparam int HI  = EXP + TOL_US;
    assign loLim[g] = CNT_W'(LO);
    assign hiLim[g] = CNT_W'(HI);
  end

  // synchroniser and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waveSync <= 2'b00;
      wavePrev <= 1'b0;
    end else begin
      waveSync <= {waveSync[0], waveIn};
      wavePrev <= waveSync[1];
    end
  end

  assign edgeNow = waveSync[1] ^ wavePrev;
  assign fallNow = wavePrev & ~waveSync[1];

  // saturating 1 us duration counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segCnt <= '0;
    end else if (edgeNow) begin
      segCnt <= tick ? CNT_W'(1) : '0;
    end else if (!ctl.countEn) begin
      segCnt <= '0;
    end else if (tick && (segCnt != '1)) begin
      segCnt <= segCnt + CNT_W'(1);
    end
  end

  assign inWindow = (segCnt >= loLim[segIdx]) && (segCnt <= hiLim[segIdx]);

  always_comb begin
    st.fall    = fallNow;
    st.segPass = ctl.checkEn && edgeNow && inWindow;
    st.segMiss = ctl.checkEn && edgeNow && !inWindow;
  end

  // R1: one step per tick while counting
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !edgeNow && tick && (segCnt != '1)) |=> (segCnt == $past(segCnt) + CNT_W'(1)));

  // R1: an edge restarts the measurement
  p_edge_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    edgeNow |=> (segCnt <= CNT_W'(1)));

  // R11: saturation holds, never wraps
  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !edgeNow && (segCnt == '1)) |=> (segCnt == '1));

endmodule

// File: rtl/pulseChkControl.sv
module pulseChkControl
  import pulseChkPkg::*;
#(
  parameter int NUM_SEG  = 12,
  parameter int PASS_RUN = 13,
  parameter int SEG_W    = 4,
  parameter int RUN_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  dpStatus_t        st,
  output ctlStrobe_t       ctl,
  output logic [SEG_W-1:0] segIdx,
  output logic             go,
  output logic             noGo,
  output logic             segErr
);

  chkState_t        state;
  logic             frameBad;
  logic [RUN_W-1:0] passRun;
  logic             lastSeg;
  logic             measuring;
  logic             abortNow;
  logic             segFailNow;
  logic             framePassNow;
  logic             failNow;

  always_comb begin
    lastSeg      = (segIdx == SEG_W'(NUM_SEG - 1));
    measuring    = (state == S_MEAS) && !frameStart;
    abortNow     = frameStart && (state != S_IDLE);
    segFailNow   = measuring && st.segMiss;
    framePassNow = measuring && st.segPass && lastSeg && !frameBad;
    failNow      = abortNow || segFailNow;
    ctl.countEn  = (state == S_MEAS);
    ctl.checkEn  = (state == S_MEAS);
  end

  // frame sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      segIdx   <= '0;
      frameBad <= 1'b0;
    end else if (frameStart) begin
      state    <= S_ARM;
      segIdx   <= '0;
      frameBad <= 1'b0;
    end else begin
      unique case (state)
        S_ARM: begin
          if (st.fall) begin
            state  <= S_MEAS;
            segIdx <= '0;
          end
        end
        S_MEAS: begin
          if (st.segPass || st.segMiss) begin
            if (st.segMiss) frameBad <= 1'b1;
            if (lastSeg) state <= S_IDLE;
            else segIdx <= segIdx + SEG_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // verdict flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      passRun <= '0;
      go      <= 1'b0;
      noGo    <= 1'b0;
      segErr  <= 1'b0;
    end else if (failNow) begin
      passRun <= '0;
      go      <= 1'b0;
      noGo    <= 1'b1;
      segErr  <= 1'b1;
    end else begin
      segErr <= 1'b0;
      if (framePassNow) begin
        if (passRun < RUN_W'(PASS_RUN)) passRun <= passRun + RUN_W'(1);
        if (passRun >= RUN_W'(PASS_RUN - 1)) begin
          go   <= 1'b1;
          noGo <= 1'b0;
        end
      end
    end
  end

  // R5: indicators exclusive
  p_verdict_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(go && noGo));

  // R5: an error pulse always comes with no-go
  p_err_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    segErr |-> (noGo && !go));

  // R6: go only rises with a full run
  p_go_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(go) |-> (passRun == RUN_W'(PASS_RUN)));

  // R7: go holds without failure
  p_go_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (go && !failNow) |=> go);

  // R8: an aborted frame reports an error
  p_abort_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortNow |=> (segErr && noGo));

  // R10: nothing reported while not armed
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && !frameStart) |=> !segErr);

  // R2: segment index stays within the frame
  p_seg_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(segIdx) < NUM_SEG);

endmodule

// File: rtl/pulseTimingChecker.sv
module pulseTimingChecker
  import pulseChkPkg::*;
#(
  parameter int NUM_PULSES = 6,
  parameter int PULSE_US   = 1500,
  parameter int GAP_US     = 200,
  parameter int TRAIL_US   = 200,
  parameter int TOL_US     = 10,
  parameter int PASS_RUN   = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic frameStart,
  input  logic waveIn,
  output logic go,
  output logic noGo,
  output logic segErr
);

  localparam int NUM_SEG = 2 * NUM_PULSES;
  localparam int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam int MAX_EXP = (PULSE_US > GAP_US)
                           ? ((PULSE_US > TRAIL_US) ? PULSE_US : TRAIL_US)
                           : ((GAP_US > TRAIL_US) ? GAP_US : TRAIL_US);
  localparam int MAX_LIM = MAX_EXP + TOL_US;
  localparam int CNT_W   = $clog2(MAX_LIM + 2);
  localparam int RUN_W   = $clog2(PASS_RUN + 1);

  ctlStrobe_t       ctl;
  dpStatus_t        st;
  logic [SEG_W-1:0] segIdx;

  pulseChkDatapath #(
    .NUM_SEG (NUM_SEG),
    .PULSE_US(PULSE_US),
    .GAP_US  (GAP_US),
    .TRAIL_US(TRAIL_US),
    .TOL_US  (TOL_US),
    .CNT_W   (CNT_W),
    .SEG_W   (SEG_W)
  ) uDatapath (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .waveIn(waveIn),
    .ctl   (ctl),
    .segIdx(segIdx),
    .st    (st)
  );

  pulseChkControl #(
    .NUM_SEG (NUM_SEG),
    .PASS_RUN(PASS_RUN),
    .SEG_W   (SEG_W),
    .RUN_W   (RUN_W)
  ) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .st        (st),
    .ctl       (ctl),
    .segIdx    (segIdx),
    .go        (go),
    .noGo      (noGo),
    .segErr    (segErr)
  );

endmodule

// File: tb/pulseTimingChecker_test.sv
module pulseTimingChecker_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int NP         = 6;
  localparam int NSEG       = 2 * NP;
  localparam int PUL        = 60;
  localparam int GAP        = 20;
  localparam int TRL        = 16;
  localparam int TOL        = 3;
  localparam int RUN        = 13;
  localparam int WRAP       = 128;  // counter modulus for these parameters

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic frameStart = 1'b0;
  logic waveIn = 1'b0;
  logic go, noGo, segErr;

  pulseTimingChecker #(
    .NUM_PULSES(NP),
    .PULSE_US  (PUL),
    .GAP_US    (GAP),
    .TRAIL_US  (TRL),
    .TOL_US    (TOL),
    .PASS_RUN  (RUN)
  ) uut (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .frameStart(frameStart),
    .waveIn    (waveIn),
    .go        (go),
    .noGo      (noGo),
    .segErr    (segErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int phase = 0;
  always @(negedge clk) begin
    phase = (phase + 1) % TICK_DIV;
    tick  = (phase == 0);
  end

  int errSeen = 0;
  always @(negedge clk) if (segErr === 1'b1) errSeen++;

  int checks = 0;
  int fails = 0;
  int mRun = 0;
  bit mGo = 0;
  bit mNoGo = 0;
  bit abortPending = 0;
  int dur [NSEG];

  function automatic int expUs(int i);
    if (i == NSEG - 1) return TRL;
    else if (i % 2 == 0) return PUL;
    else return GAP;
  endfunction

  function automatic bit segOk(int i, int d);
    return (d >= expUs(i) - TOL) && (d <= expUs(i) + TOL);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelFail();
    mRun = 0; mGo = 0; mNoGo = 1;
  endtask

  task automatic modelPass();
    if (mRun < RUN) mRun++;
    if (mRun >= RUN) begin mGo = 1; mNoGo = 0; end
  endtask

  task automatic hold(bit lvl, int us);
    waveIn = lvl;
    repeat (us * TICK_DIV) @(negedge clk);
  endtask

  task automatic setNominal();
    for (int i = 0; i < NSEG; i++) dur[i] = expUs(i);
  endtask

  // plays dur[0..nDone-1]; closes the frame only when nDone == NSEG
  task automatic runChecked(string req, int nDone);
    int base;
    int expErr;
    int nEval;
    int nBad;
    base = errSeen;
    expErr = 0;
    if (abortPending) begin
      expErr = 1;
      modelFail();
      abortPending = 0;
    end
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    hold(1'b1, 4);
    for (int i = 0; i < nDone; i++) hold((i % 2 == 0) ? 1'b0 : 1'b1, dur[i]);
    if (nDone == NSEG) hold(1'b0, 4);
    else repeat (8) @(negedge clk);
    nEval = (nDone == NSEG) ? NSEG : nDone - 1;
    nBad = 0;
    for (int i = 0; i < nEval; i++) if (!segOk(i, dur[i])) nBad++;
    expErr += nBad;
    if (nBad > 0) modelFail();
    else if (nDone == NSEG) modelPass();
    if (nDone != NSEG) abortPending = 1;
    chk(req, "segErr pulses", errSeen - base, expErr);
    chk(req, "go", int'(go), int'(mGo));
    chk(req, "noGo", int'(noGo), int'(mNoGo));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int seed;
    int base;
    seed = $urandom(32'd4817);
    // R9: reset state
    repeat (5) @(negedge clk);
    chk("R9", "go at reset", int'(go), 0);
    chk("R9", "noGo at reset", int'(noGo), 0);
    chk("R9", "segErr at reset", int'(segErr), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R10: edges before any frame is armed
    base = errSeen;
    hold(1'b1, 7); hold(1'b0, 5); hold(1'b1, 60); hold(1'b0, 9);
    chk("R10", "errors while idle", errSeen - base, 0);
    chk("R10", "noGo while idle", int'(noGo), 0);

    // R3/R6: 13 passing frames, limits exercised; go only at the 13th
    for (int f = 0; f < RUN; f++) begin
      setNominal();
      dur[f % NSEG] = expUs(f % NSEG) + ((f % 2 == 0) ? TOL : -TOL);
      runChecked((f == 0) ? "R9" : "R3", NSEG);
      chk("R6", "go during run", int'(go), (f == RUN - 1) ? 1 : 0);
    end

    // R7: go holds while frames keep passing
    for (int f = 0; f < 3; f++) begin
      setNominal();
      runChecked("R7", NSEG);
      chk("R7", "go held", int'(go), 1);
    end

    // R10: stray edges after a completed frame
    base = errSeen;
    hold(1'b1, 5); hold(1'b0, 3); hold(1'b1, 2); hold(1'b0, 6);
    chk("R10", "errors after frame", errSeen - base, 0);
    chk("R10", "go after stray edges", int'(go), 1);

    // R1/R4/R5: one tick beyond the limit on a gap
    setNominal();
    dur[3] = GAP + TOL + 1;
    runChecked("R1", NSEG);
    chk("R5", "go cleared", int'(go), 0);
    chk("R5", "noGo set", int'(noGo), 1);

    // R2: trailing interval timed like a gap fails
    setNominal();
    dur[NSEG - 1] = GAP;
    runChecked("R2", NSEG);

    // R11: wrap-length pulse must not pass
    setNominal();
    dur[0] = PUL + WRAP;
    runChecked("R11", NSEG);

    // R8: incomplete frame, then a good one
    setNominal();
    runChecked("R8", 5);
    setNominal();
    runChecked("R8", NSEG);
    chk("R8", "noGo after abort", int'(noGo), 1);

    // R4: two failing segments in one frame
    setNominal();
    dur[2] = PUL - TOL - 1;
    dur[7] = GAP + TOL + 2;
    runChecked("R4", NSEG);

    // random frames checked against the model
    for (int f = 0; f < 28; f++) begin
      int mode;
      int nDone;
      mode = int'($urandom_range(0, 9));
      for (int i = 0; i < NSEG; i++) begin
        if (mode < 6) dur[i] = expUs(i) + int'($urandom_range(0, 2 * TOL)) - TOL;
        else dur[i] = expUs(i) + int'($urandom_range(0, 2 * TOL + 6)) - TOL - 3;
      end
      nDone = (mode == 9) ? int'($urandom_range(2, NSEG - 1)) : NSEG;
      runChecked("R3", nDone);
    end

    // R6: recover to go with a fresh run
    for (int f = 0; f < RUN; f++) begin
      setNominal();
      runChecked("R6", NSEG);
    end
    chk("R6", "go after recovery", int'(go), 1);

    summary();
    $finish;
  end

endmodule